// File: doc/BRIEF.md
# Byte ALU with Status Flag Update

This block is the arithmetic and logic datapath of a small 8-bit processor core. It is purely combinational. It takes two byte operands, a 5-bit operation select and the six current status flags. In the same cycle it returns the byte result, a write-back strobe for the destination register, the next value of every flag and a mask that shows which flags the operation updates.

Each flag is derived from bit-level boolean terms on the operands and the result. The chained subtract and compare forms hold the zero flag across bytes, so a 16-bit or wider compare built from byte steps reports zero only when every byte was zero. Instruction decode, the register file and multiplication are handled elsewhere in the core. The block only needs an operation code and the two register values.

Flag vector layout, used on `flg_in`, `flg_out` and `flg_upd`: bit 0 carry (C), bit 1 zero (Z), bit 2 negative (N), bit 3 overflow (V), bit 4 sign (S), bit 5 half carry (H).

Top module: `alu8_core`

## Requirements
- R1: Codes 0 (add) and 1 (add with carry-in C) write `a+b(+C)` back and update all six flags (mask 0x3F). For carry out of bit k (k=3 gives H, k=7 gives C) the rule is `(a&b)|(b&~r)|(~r&a)`. V is `(a7&b7&~r7)|(~a7&~b7&r7)`.
- R2: Codes 2 (subtract) and 3 (subtract with borrow-in C) write `a-b(-C)` back and update all six flags. The borrow out of bit k (3 for H, 7 for C) is `(~a&b)|(b&r)|(r&~a)`. V is `(a7&~b7&~r7)|(~a7&b7&r7)`.
- R3: For codes 3 and 5 (the borrow-chained forms), Z out is set only when the result is zero and Z in was already set. A nonzero result clears Z.
- R4: Codes 4 (compare) and 5 (compare with borrow-in) set the flags exactly as subtraction does, and hold the write-back strobe low.
- R5: Whenever S is updated it equals N xor V, and N equals bit 7 of the result.
- R6: Codes 6 (AND), 7 (OR) and 8 (XOR) combine a with b. Code 9 (complement) gives `~a` and sets C to 1. All four clear V. They leave H unchanged. Codes 6 to 8 also leave C unchanged (mask 0x1E for 6 to 8, 0x1F for 9).
- R7: Code 11 (increment) sets V when a was 0x7F. Code 12 (decrement) sets V when the result is 0x7F. Both leave C and H unchanged (mask 0x1E).
- R8: Code 10 (negate) gives `0-a`. V is set when the result is 0x80, and C when the result is nonzero. H is result bit 3 OR operand bit 3. The mask is 0x3F.
- R9: Codes 13 (arithmetic right), 14 (logical right) and 15 (rotate right through C) put a[0] in C and set V to N xor C. Bit 7 is kept by code 13, cleared by code 14 and loaded from C in by code 15. The mask is 0x1F.
- R10: Code 16 exchanges the two nibbles of a, writes the result back and changes no flag (mask 0).
- R11: For every flag whose mask bit is 0, the output flag equals the input flag.
- R12: Codes 17 to 31 give result 0, write-back low and mask 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 8 | First operand (destination register value) |
| op_b | input | 8 | Second operand (source register or immediate) |
| op_sel | input | 5 | Operation code, see requirements |
| flg_in | input | 6 | Current status flags |
| res | output | 8 | Byte result |
| res_we | output | 1 | Write result back to the destination |
| flg_out | output | 6 | Next status flags, unchanged where not updated |
| flg_upd | output | 6 | Mask of flags this operation updates |

## Verification
The assertions sample the outputs only after the combinational logic has settled. They assume all inputs are driven to known 0/1 values, because an unknown operation code or flag bit would make their implications meaningless. The bench changes inputs just after a rising edge and compares on the falling edge, so every vector has settled before it is checked. It also covers the unused code range as well as every defined code, so the idle guarantees are exercised together with the defined operations.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int OPW    = 5;
  localparam int NFLAG  = 6;

  // flag vector positions
  localparam int FC = 0;
  localparam int FZ = 1;
  localparam int FN = 2;
  localparam int FV = 3;
  localparam int FS = 4;
  localparam int FH = 5;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 5'd0,
    OP_ADC  = 5'd1,
    OP_SUB  = 5'd2,
    OP_SBC  = 5'd3,
    OP_CMP  = 5'd4,
    OP_CPC  = 5'd5,
    OP_AND  = 5'd6,
    OP_OR   = 5'd7,
    OP_XOR  = 5'd8,
    OP_COM  = 5'd9,
    OP_NEG  = 5'd10,
    OP_INC  = 5'd11,
    OP_DEC  = 5'd12,
    OP_ASR  = 5'd13,
    OP_LSR  = 5'd14,
    OP_ROR  = 5'd15,
    OP_SWAP = 5'd16
  } alu_op_e;

  typedef enum logic [1:0] {
    SRC_NONE,
    SRC_ARITH,
    SRC_LOGIC,
    SRC_SHIFT
  } res_src_e;

  typedef enum logic [1:0] {
    LG_AND,
    LG_OR,
    LG_XOR,
    LG_COM
  } logic_mode_e;

  typedef enum logic [1:0] {
    SH_ASR,
    SH_LSR,
    SH_ROR,
    SH_SWAP
  } shift_mode_e;

  typedef enum logic [1:0] {
    VSRC_ARITH,
    VSRC_CLEAR,
    VSRC_SHIFT
  } vsrc_e;

  // mask constants
  localparam logic [NFLAG-1:0] UPD_ALL   = 6'b11_1111;
  localparam logic [NFLAG-1:0] UPD_SVNZ  = 6'b01_1110;
  localparam logic [NFLAG-1:0] UPD_SVNZC = 6'b01_1111;
  localparam logic [NFLAG-1:0] UPD_NONE  = 6'b00_0000;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic             cin,
  input  logic             sub,
  output logic [WIDTH-1:0] r,
  output logic             half_cy,
  output logic             top_cy,
  output logic             ovf
);
  localparam int MSB = WIDTH - 1;
  localparam int HB  = WIDTH / 2 - 1;

  logic [WIDTH-1:0] cin_ext;
  logic [WIDTH-1:0] cy;

  assign cin_ext = {{(WIDTH-1){1'b0}}, cin};

  always_comb begin
    if (sub) r = x - y - cin_ext;
    else     r = x + y + cin_ext;
  end

  // per-bit carry/borrow out recovered from operand and result bits
  for (genvar k = 0; k < WIDTH; k++) begin : g_cy
    always_comb begin
      if (sub) cy[k] = (~x[k] & y[k]) | (y[k] & r[k]) | (r[k] & ~x[k]);
      else     cy[k] = (x[k] & y[k]) | (y[k] & ~r[k]) | (~r[k] & x[k]);
    end
  end

  assign half_cy = cy[HB];
  assign top_cy  = cy[MSB];

  always_comb begin
    if (sub) ovf = (x[MSB] & ~y[MSB] & ~r[MSB]) | (~x[MSB] & y[MSB] & r[MSB]);
    else     ovf = (x[MSB] & y[MSB] & ~r[MSB]) | (~x[MSB] & ~y[MSB] & r[MSB]);
  end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic_mode_e      mode,
  output logic [WIDTH-1:0] r
);
  always_comb begin
    unique case (mode)
      LG_AND:  r = x & y;
      LG_OR:   r = x | y;
      LG_XOR:  r = x ^ y;
      default: r = ~x;
    endcase
  end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] x,
  input  logic             cin,
  input  shift_mode_e      mode,
  output logic [WIDTH-1:0] r,
  output logic             cout
);
  localparam int MSB  = WIDTH - 1;
  localparam int HALF = WIDTH / 2;

  logic fill;

  always_comb begin
    unique case (mode)
      SH_ASR:  fill = x[MSB];
      SH_ROR:  fill = cin;
      default: fill = 1'b0;
    endcase
  end

  always_comb begin
    if (mode == SH_SWAP) r = {x[HALF-1:0], x[MSB:HALF]};
    else                 r = {fill, x[MSB:1]};
  end

  assign cout = x[0];
endmodule

// File: rtl/alu8_flagmerge.sv
module alu8_flagmerge #(
  parameter int NF = 6
) (
  input  logic [NF-1:0] cur,
  input  logic [NF-1:0] nxt,
  input  logic [NF-1:0] upd,
  output logic [NF-1:0] merged
);
  for (genvar i = 0; i < NF; i++) begin : g_bit
    assign merged[i] = upd[i] ? nxt[i] : cur[i];
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [OPW-1:0]   op_sel,
  input  logic [NFLAG-1:0] flg_in,
  output logic [WIDTH-1:0] res,
  output logic             res_we,
  output logic [NFLAG-1:0] flg_out,
  output logic [NFLAG-1:0] flg_upd
);
  localparam int MSB = WIDTH - 1;
  localparam logic [WIDTH-1:0] ZERO = '0;
  localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};

  // decode controls
  logic [WIDTH-1:0] as_x, as_y;
  logic             as_cin, as_sub;
  logic_mode_e      lg_mode;
  shift_mode_e      sh_mode;
  res_src_e         src;
  vsrc_e            vsrc;
  logic             z_sticky, c_force, neg_h;

  // unit outputs
  logic [WIDTH-1:0] as_r, lg_r, sh_r;
  logic             as_h, as_c, as_v, sh_c;

  logic [NFLAG-1:0] nf;

  always_comb begin
    as_x     = op_a;
    as_y     = op_b;
    as_cin   = 1'b0;
    as_sub   = 1'b0;
    lg_mode  = LG_AND;
    sh_mode  = SH_LSR;
    src      = SRC_NONE;
    vsrc     = VSRC_ARITH;
    z_sticky = 1'b0;
    c_force  = 1'b0;
    neg_h    = 1'b0;
    res_we   = 1'b0;
    flg_upd  = UPD_NONE;
    case (op_sel)
      OP_ADD, OP_ADC: begin
        as_cin  = (op_sel == OP_ADC) & flg_in[FC];
        src     = SRC_ARITH;
        res_we  = 1'b1;
        flg_upd = UPD_ALL;
      end
      OP_SUB, OP_SBC, OP_CMP, OP_CPC: begin
        as_sub   = 1'b1;
        as_cin   = ((op_sel == OP_SBC) | (op_sel == OP_CPC)) & flg_in[FC];
        z_sticky = (op_sel == OP_SBC) | (op_sel == OP_CPC);
        src      = SRC_ARITH;
        res_we   = (op_sel == OP_SUB) | (op_sel == OP_SBC);
        flg_upd  = UPD_ALL;
      end
      OP_AND, OP_OR, OP_XOR: begin
        lg_mode = (op_sel == OP_AND) ? LG_AND :
                  (op_sel == OP_OR)  ? LG_OR  : LG_XOR;
        src     = SRC_LOGIC;
        vsrc    = VSRC_CLEAR;
        res_we  = 1'b1;
        flg_upd = UPD_SVNZ;
      end
      OP_COM: begin
        lg_mode = LG_COM;
        src     = SRC_LOGIC;
        vsrc    = VSRC_CLEAR;
        c_force = 1'b1;
        res_we  = 1'b1;
        flg_upd = UPD_SVNZC;
      end
      OP_NEG: begin
        as_x    = ZERO;
        as_y    = op_a;
        as_sub  = 1'b1;
        neg_h   = 1'b1;
        src     = SRC_ARITH;
        res_we  = 1'b1;
        flg_upd = UPD_ALL;
      end
      OP_INC, OP_DEC: begin
        as_y    = ONE;
        as_sub  = (op_sel == OP_DEC);
        src     = SRC_ARITH;
        res_we  = 1'b1;
        flg_upd = UPD_SVNZ;
      end
      OP_ASR, OP_LSR, OP_ROR: begin
        sh_mode = (op_sel == OP_ASR) ? SH_ASR :
                  (op_sel == OP_LSR) ? SH_LSR : SH_ROR;
        src     = SRC_SHIFT;
        vsrc    = VSRC_SHIFT;
        res_we  = 1'b1;
        flg_upd = UPD_SVNZC;
      end
      OP_SWAP: begin
        sh_mode = SH_SWAP;
        src     = SRC_SHIFT;
        res_we  = 1'b1;
        flg_upd = UPD_NONE;
      end
      default: ;
    endcase
  end

  alu8_addsub #(.WIDTH(WIDTH)) u_addsub (
    .x       (as_x),
    .y       (as_y),
    .cin     (as_cin),
    .sub     (as_sub),
    .r       (as_r),
    .half_cy (as_h),
    .top_cy  (as_c),
    .ovf     (as_v)
  );

  alu8_logic #(.WIDTH(WIDTH)) u_logic (
    .x    (op_a),
    .y    (op_b),
    .mode (lg_mode),
    .r    (lg_r)
  );

  alu8_shift #(.WIDTH(WIDTH)) u_shift (
    .x    (op_a),
    .cin  (flg_in[FC]),
    .mode (sh_mode),
    .r    (sh_r),
    .cout (sh_c)
  );

  always_comb begin
    unique case (src)
      SRC_ARITH: res = as_r;
      SRC_LOGIC: res = lg_r;
      SRC_SHIFT: res = sh_r;
      default:   res = ZERO;
    endcase
  end

  // candidate flag values; the mask decides which ones land
  always_comb begin
    nf     = '0;
    nf[FN] = res[MSB];
    nf[FZ] = (res == ZERO) & (~z_sticky | flg_in[FZ]);
    unique case (vsrc)
      VSRC_ARITH: nf[FV] = as_v;
      VSRC_SHIFT: nf[FV] = res[MSB] ^ sh_c;
      default:    nf[FV] = 1'b0;
    endcase
    nf[FS] = nf[FN] ^ nf[FV];
    nf[FH] = neg_h ? (as_r[3] | op_a[3]) : as_h;
    if (c_force)               nf[FC] = 1'b1;
    else if (src == SRC_SHIFT) nf[FC] = sh_c;
    else                       nf[FC] = as_c;
  end

  alu8_flagmerge #(.NF(NFLAG)) u_merge (
    .cur    (flg_in),
    .nxt    (nf),
    .upd    (flg_upd),
    .merged (flg_out)
  );

endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic [OPW-1:0]   op_sel,
  input logic [NFLAG-1:0] flg_in,
  input logic [WIDTH-1:0] res,
  input logic             res_we,
  input logic [NFLAG-1:0] flg_out,
  input logic [NFLAG-1:0] flg_upd
);
  localparam int MSB  = WIDTH - 1;
  localparam int HALF = WIDTH / 2;

  logic [WIDTH-1:0] b_seen;
  assign b_seen = op_b;

  always_comb begin
    if (flg_upd[FS]) begin
      assert_sign_rule_R5: assert (flg_out[FS] == (flg_out[FN] ^ flg_out[FV]));
    end
    if (flg_upd[FN]) begin
      assert_neg_msb_R5: assert (flg_out[FN] == res[MSB]);
    end
    assert_keep_unmasked_R11: assert (((flg_out ^ flg_in) & ~flg_upd) == '0);
    if (op_sel == OP_CMP || op_sel == OP_CPC) begin
      assert_cmp_nowrite_R4: assert (!res_we);
    end
    if ((op_sel == OP_SBC || op_sel == OP_CPC) && !flg_in[FZ]) begin
      assert_sticky_zero_R3: assert (!flg_out[FZ]);
    end
    if (op_sel == OP_INC || op_sel == OP_DEC) begin
      assert_incdec_carry_R7: assert (flg_out[FC] == flg_in[FC] && flg_out[FH] == flg_in[FH]);
    end
    if (op_sel == OP_ASR || op_sel == OP_LSR || op_sel == OP_ROR) begin
      assert_shift_carry_R9: assert (flg_out[FC] == op_a[0]);
    end
    if (op_sel == OP_SWAP) begin
      assert_swap_quiet_R10: assert (flg_out == flg_in &&
                                     res == {op_a[HALF-1:0], op_a[MSB:HALF]});
    end
    if (op_sel > OP_SWAP) begin
      assert_idle_code_R12: assert (!res_we && flg_upd == '0 && res == '0 && b_seen == op_b);
    end
  end
endmodule

bind alu8_core alu8_core_chk #(.WIDTH(WIDTH)) u_chk (
  .op_a    (op_a),
  .op_b    (op_b),
  .op_sel  (op_sel),
  .flg_in  (flg_in),
  .res     (res),
  .res_we  (res_we),
  .flg_out (flg_out),
  .flg_upd (flg_upd)
);

// File: tb/alu8_core_tb.sv
module alu8_core_tb;
  logic       clk;
  logic       rst_n;
  logic [7:0] a, b;
  logic [4:0] sel;
  logic [5:0] fin;
  logic [7:0] res;
  logic       we;
  logic [5:0] fout, fupd;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 0;

  alu8_core u_dut (
    .op_a    (a),
    .op_b    (b),
    .op_sel  (sel),
    .flg_in  (fin),
    .res     (res),
    .res_we  (we),
    .flg_out (fout),
    .flg_upd (fupd)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic string req_tag(int op);
    case (op)
      0, 1:        return "R1";
      2:           return "R2";
      3:           return "R3";
      4, 5:        return "R4";
      6, 7, 8, 9:  return "R6";
      10:          return "R8";
      11, 12:      return "R7";
      13, 14, 15:  return "R9";
      16:          return "R10";
      default:     return "R12";
    endcase
  endfunction

  function automatic int sx(int v);
    return (v >= 128) ? v - 256 : v;
  endfunction

  // behavioural reference of R1..R12; flag positions C0 Z1 N2 V3 S4 H5
  task automatic apply(input int op, input int va, input int vb, input int vf);
    int r, s, sv, cin, m, ew;
    int c, z, n, v, h;
    int nf, ef;
    @(posedge clk);
    #1;
    a = va[7:0]; b = vb[7:0]; sel = op[4:0]; fin = vf[5:0];
    cin = vf & 1;
    c = cin; h = (vf >> 5) & 1; v = 0; z = 0;
    r = 0; m = 0; ew = 1;
    case (op)
      0, 1: begin
        if (op == 0) cin = 0;
        s = va + vb + cin; r = s & 255; c = (s > 255);
        h = (((va & 15) + (vb & 15) + cin) > 15);
        sv = sx(va) + sx(vb) + cin; v = (sv > 127 || sv < -128); m = 63;
      end
      2, 3, 4, 5: begin
        if (op == 2 || op == 4) cin = 0;
        s = va - vb - cin; r = s & 255; c = (s < 0);
        h = (((va & 15) - (vb & 15) - cin) < 0);
        sv = sx(va) - sx(vb) - cin; v = (sv > 127 || sv < -128); m = 63;
        if (op >= 4) ew = 0;
      end
      6: begin r = va & vb; m = 30; end
      7: begin r = va | vb; m = 30; end
      8: begin r = va ^ vb; m = 30; end
      9: begin r = 255 - va; c = 1; m = 31; end
      10: begin
        r = (256 - va) & 255; h = ((r >> 3) | (va >> 3)) & 1;
        v = (r == 128); c = (r != 0); m = 63;
      end
      11: begin r = (va + 1) & 255; v = (va == 127); m = 30; end
      12: begin r = (va + 255) & 255; v = (r == 127); m = 30; end
      13, 14, 15: begin
        r = va >> 1;
        if (op == 13) r = r | (va & 128);
        if (op == 15) r = r | (cin << 7);
        c = va & 1; v = ((r >> 7) & 1) ^ c; m = 31;
      end
      16: begin r = ((va << 4) & 240) | (va >> 4); m = 0; end
      default: begin r = 0; ew = 0; m = 0; end
    endcase
    n = (r >> 7) & 1;
    z = (r == 0);
    if (op == 3 || op == 5) z = z & ((vf >> 1) & 1);
    nf = c | (z << 1) | (n << 2) | (v << 3) | ((n ^ v) << 4) | (h << 5);
    ef = (nf & m) | (vf & ~m & 63);
    @(negedge clk);
    n_vec++;
    if (res !== r[7:0] || we !== ew[0] || fupd !== m[5:0] || fout !== ef[5:0]) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%02h b=%02h f=%02h: got res=%02h we=%0d upd=%02h flg=%02h, expected res=%02h we=%0d upd=%02h flg=%02h",
               req_tag(op), op, va, vb, vf, res, we, fupd, fout, r, ew, m, ef);
    end
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    a = '0; b = '0; sel = '0; fin = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // idle inputs: all-zero add gives zero result with Z set (R1)
    apply(0, 0, 0, 0);
    // R1 corners: signed overflow, carry and half carry, carry-in
    apply(0, 8'h7F, 8'h01, 0);
    apply(0, 8'hFF, 8'h01, 0);
    apply(1, 8'hFF, 8'h00, 1);
    apply(1, 8'h0F, 8'h00, 1);
    // R2 borrow and overflow
    apply(2, 8'h00, 8'h01, 0);
    apply(2, 8'h80, 8'h01, 0);
    // R3 sticky zero, both input Z values
    apply(3, 8'h05, 8'h04, 6'h01);
    apply(3, 8'h05, 8'h04, 6'h03);
    apply(5, 8'h10, 8'h10, 6'h00);
    apply(5, 8'h10, 8'h10, 6'h02);
    // R4 compare without write-back
    apply(4, 8'h40, 8'h41, 6'h3F);
    // R6 logic and complement
    apply(6, 8'hF0, 8'h0F, 6'h2B);
    apply(9, 8'h00, 8'h00, 6'h00);
    // R7 inc/dec overflow edges
    apply(11, 8'h7F, 8'h00, 6'h21);
    apply(12, 8'h80, 8'h00, 6'h00);
    apply(11, 8'hFF, 8'h00, 6'h00);
    // R8 negate edges
    apply(10, 8'h80, 8'h00, 0);
    apply(10, 8'h00, 8'h00, 6'h3F);
    apply(10, 8'h01, 8'h00, 0);
    // R9 shifts and rotate with carry in
    apply(13, 8'h81, 8'h00, 0);
    apply(14, 8'h81, 8'h00, 0);
    apply(15, 8'h02, 8'h00, 1);
    // R10 swap keeps flags, R12 unused code
    apply(16, 8'hA5, 8'h00, 6'h2A);
    apply(31, 8'hFF, 8'hFF, 6'h15);
    // sweep every code, R5 and R11 checked on each vector
    seed = 32'h1234_5678;
    for (int op = 0; op < 32; op++) begin
      for (int k = 0; k < 1200; k++) begin
        int va, vb, vf;
        seed = seed * 1103515245 + 12345;
        va = (seed >> 8) & 255;
        vb = (seed >> 16) & 255;
        vf = (seed >> 24) & 63;
        apply(op, va, vb, vf);
      end
    end
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule